// File: doc/BRIEF.md
# Configurable Registered Fan-Out Buffer

This block is a single clocked register stage for a bank of address and command lines. On every rising clock edge it captures a 25-bit input bus and presents it on two output banks. Two static select inputs set how the stage is used. With the duplicate select low, the stage is a wide buffer: each used input drives one output on bank A, and bank B stays at zero. With the duplicate select high, the stage is a narrower buffer: each used input drives the same bit position on both banks, so a second load gets its own copy.

In duplicated mode, the map select picks which subset of the inputs is live. With the map select low, the stage uses the A-side bits, which suits the first device of a pair. With the map select high, it uses the B-side bits, which suits the second device. Inputs that the current configuration does not use are ignored, and their output positions are held low. An active-low reset clears every output asynchronously.

Bit i of the input and output buses is line number i+1 (line 1 is bit 0). A parameter chooses one of two implementations of the second bank: a separate flop per copy, or a shared flop with one registered mode bit.

Top module: `fob_buffer`

## Requirements
- R1: The outputs change only on a rising clock edge. An input change between edges leaves the outputs unchanged until the next rising edge, which then shows the input value present at that edge.
- R2: With cfg_dup = 0 (wide mode), after an edge qa equals din masked to line numbers 2, 3, 5, 6 and 8 to 25 (mask 25'h1FFFFB6), and qb is all zero.
- R3: With cfg_dup = 1 and cfg_map = 0, after an edge both qa and qb equal din masked to line numbers 2, 3, 5, 6 and 8 to 14 (mask 25'h0003FB6).
- R4: With cfg_dup = 1 and cfg_map = 1, after an edge both qa and qb equal din masked to line numbers 1 to 6, 8 to 10, 12 and 13 (mask 25'h0001BBF).
- R5: An output position that the current configuration does not use is driven 0, whatever value its input carries. Line 7 (bit 6) is unused in every configuration.
- R6: In duplicated mode, qa and qb update on the same edge and carry identical values.
- R7: While rst_n is 0, qa and qb are all zero. Asserting rst_n clears both banks at once, without waiting for a clock edge.
- R8: A change of cfg_map or cfg_dup takes effect at the next rising edge. The outputs keep the old mapping until that edge.
- R9: In wide mode, cfg_map has no effect on either output bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_map | input | 1 | Duplicated-mode map select: 0 = A-side bits, 1 = B-side bits |
| cfg_dup | input | 1 | Mode select: 0 = wide single copy, 1 = duplicated |
| din | input | 25 | Input bus; bit i is line i+1 |
| qa | output | 25 | First output bank |
| qb | output | 25 | Second output bank; copy of qa in duplicated mode, zero in wide mode |

## Verification
The bench sets din to all ones and to alternating patterns in each of the three configurations. A mask with a wrong bit would show a live position held at zero, or an unused position (bits 0, 3 and 6 in wide mode) following its input. Wide mode is run with cfg_map at both values, so a decoder that lets cfg_map leak into wide mode would change qa or raise qb. The bench switches configuration and data away from a clock edge and checks the outputs before and after the next edge. A design that applied the mask without a register, or that sampled late, would change the outputs early. A mid-cycle reset is checked before any clock edge arrives, which exposes a synchronous reset.

// File: rtl/fob_pkg.sv
package fob_pkg;

   typedef enum logic [1:0] {
      FOB_WIDE  = 2'd0,
      FOB_DUP_A = 2'd1,
      FOB_DUP_B = 2'd2
   } fob_mode_e;

   // Select pins to operating mode; the map select matters only when duplicating.
   function automatic fob_mode_e fob_decode(input logic sel_map, input logic sel_dup);
      if (!sel_dup)
         return FOB_WIDE;
      else if (sel_map)
         return FOB_DUP_B;
      else
         return FOB_DUP_A;
   endfunction

endpackage

// File: rtl/fob_cfg_decode.sv
module fob_cfg_decode
   import fob_pkg::*;
#(
   parameter int               WIDTH      = 25,
   parameter logic [WIDTH-1:0] WIDE_MASK  = '0,
   parameter logic [WIDTH-1:0] DUP_A_MASK = '0,
   parameter logic [WIDTH-1:0] DUP_B_MASK = '0
) (
   input  logic             sel_map,
   input  logic             sel_dup,
   output logic [WIDTH-1:0] keep_a,
   output logic [WIDTH-1:0] keep_b
);

   fob_mode_e mode;

   always_comb begin
      mode = fob_decode(sel_map, sel_dup);
      unique case (mode)
         FOB_WIDE: begin
            keep_a = WIDE_MASK;
            keep_b = '0;
         end
         FOB_DUP_A: begin
            keep_a = DUP_A_MASK;
            keep_b = DUP_A_MASK;
         end
         FOB_DUP_B: begin
            keep_a = DUP_B_MASK;
            keep_b = DUP_B_MASK;
         end
         default: begin
            keep_a = '0;
            keep_b = '0;
         end
      endcase
   end

endmodule

// File: rtl/fob_bit_flop.sv
module fob_bit_flop (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic keep,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= 1'b0;
      else
         q <= d & keep;
   end

endmodule

// File: rtl/fob_buffer.sv
module fob_buffer
   import fob_pkg::*;
#(
   parameter int               WIDTH        = 25,
   parameter logic [WIDTH-1:0] WIDE_MASK    = 25'h1FFFFB6,
   parameter logic [WIDTH-1:0] DUP_A_MASK   = 25'h0003FB6,
   parameter logic [WIDTH-1:0] DUP_B_MASK   = 25'h0001BBF,
   parameter bit               SPLIT_COPIES = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_map,
   input  logic             cfg_dup,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] qa,
   output logic [WIDTH-1:0] qb
);

   localparam logic [WIDTH-1:0] USED_ANY = WIDE_MASK | DUP_A_MASK | DUP_B_MASK;

   // Elaboration-time parameter checks
   if (WIDTH < 2) begin : g_bad_width
      $error("fob_buffer: WIDTH must be at least 2");
   end
   if (WIDE_MASK == '0 || DUP_A_MASK == '0 || DUP_B_MASK == '0) begin : g_bad_mask
      $error("fob_buffer: every configuration mask needs at least one bit");
   end

   logic [WIDTH-1:0] keep_a;
   logic [WIDTH-1:0] keep_b;

   fob_cfg_decode #(
      .WIDTH      (WIDTH),
      .WIDE_MASK  (WIDE_MASK),
      .DUP_A_MASK (DUP_A_MASK),
      .DUP_B_MASK (DUP_B_MASK)
   ) u_decode (
      .sel_map (cfg_map),
      .sel_dup (cfg_dup),
      .keep_a  (keep_a),
      .keep_b  (keep_b)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bank_a
      fob_bit_flop u_flop (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (din[i]),
         .keep  (keep_a[i]),
         .q     (qa[i])
      );
   end

   if (SPLIT_COPIES) begin : g_split
      for (genvar i = 0; i < WIDTH; i++) begin : g_bank_b
         fob_bit_flop u_flop (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (din[i]),
            .keep  (keep_b[i]),
            .q     (qb[i])
         );
      end
   end else begin : g_shared
      logic dup_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dup_q <= 1'b0;
         else
            dup_q <= cfg_dup;
      end
      assign qb = qa & {WIDTH{dup_q}};
   end

   // R7
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (qa == '0 && qb == '0));

   // R1
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> qa == ($past(din) & $past(keep_a)));

   // R2
   wide_qb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_dup) |-> qb == '0);

   // R6
   copies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_dup) |-> qa == qb);

   // R5
   unused_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((qa | qb) & ~USED_ANY) == '0);

endmodule

// File: tb/fob_buffer_bench.sv
`timescale 1ns/1ps
module fob_buffer_bench;

   localparam int W = 25;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_map = 1'b0;
   logic         cfg_dup = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] qa;
   logic [W-1:0] qb;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   fob_buffer u_fob_buffer (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_map (cfg_map),
      .cfg_dup (cfg_dup),
      .din     (din),
      .qa      (qa),
      .qb      (qb)
   );

   // Masks built from the line numbers in the requirements (bit = line - 1)
   function automatic logic [W-1:0] mask_wide();
      logic [W-1:0] m = '0;
      for (int n = 1; n <= 25; n++)
         if (n != 1 && n != 4 && n != 7) m[n-1] = 1'b1;
      return m;
   endfunction

   function automatic logic [W-1:0] mask_dup_a();
      logic [W-1:0] m = '0;
      for (int n = 2; n <= 14; n++)
         if (n != 4 && n != 7) m[n-1] = 1'b1;
      return m;
   endfunction

   function automatic logic [W-1:0] mask_dup_b();
      logic [W-1:0] m = '0;
      for (int n = 1; n <= 13; n++)
         if (n != 7 && n != 11) m[n-1] = 1'b1;
      return m;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Drive away from the edge, let one edge capture, sample after it
   task automatic apply(input logic m, input logic d, input logic [W-1:0] v);
      @(negedge clk);
      cfg_map = m;
      cfg_dup = d;
      din     = v;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      #1;
      check("R7", "qa in reset", qa, '0);
      check("R7", "qb in reset", qb, '0);
      din = '1; cfg_dup = 1'b1;
      @(posedge clk); #1;
      check("R7", "qa held in reset across edge", qa, '0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_wide();
      logic [W-1:0] pats [3] = '{25'h1FFFFFF, 25'h0AAAAAA, 25'h1555555};
      for (int k = 0; k < 3; k++) begin
         apply(1'b0, 1'b0, pats[k]);
         check("R2", "wide qa", qa, pats[k] & mask_wide());
         check("R2", "wide qb low", qb, '0);
      end
      apply(1'b0, 1'b0, 25'h0000049);
      check("R5", "wide unused lines 1/4/7", qa, '0);
      apply(1'b1, 1'b0, 25'h1FFFFFF);
      check("R9", "wide qa with map=1", qa, mask_wide());
      check("R9", "wide qb with map=1", qb, '0);
   endtask

   task automatic t_dup_a();
      apply(1'b0, 1'b1, 25'h1FFFFFF);
      check("R3", "map A qa", qa, mask_dup_a());
      check("R6", "map A qb copy", qb, mask_dup_a());
      apply(1'b0, 1'b1, 25'h1555555);
      check("R3", "map A qa alt", qa, 25'h1555555 & mask_dup_a());
      check("R6", "map A qb alt", qb, 25'h1555555 & mask_dup_a());
      apply(1'b0, 1'b1, ~mask_dup_a());
      check("R5", "map A unused qa", qa, '0);
      check("R5", "map A unused qb", qb, '0);
   endtask

   task automatic t_dup_b();
      apply(1'b1, 1'b1, 25'h1FFFFFF);
      check("R4", "map B qa", qa, mask_dup_b());
      check("R6", "map B qb copy", qb, mask_dup_b());
      apply(1'b1, 1'b1, 25'h0AAAAAA);
      check("R4", "map B qa alt", qa, 25'h0AAAAAA & mask_dup_b());
      check("R6", "map B qb alt", qb, 25'h0AAAAAA & mask_dup_b());
      apply(1'b1, 1'b1, ~mask_dup_b());
      check("R5", "map B unused qa", qa, '0);
   endtask

   task automatic t_edge();
      apply(1'b0, 1'b0, 25'h0F0F0F0);
      @(negedge clk);
      din = 25'h1234567;
      #1;
      check("R1", "qa before edge", qa, 25'h0F0F0F0 & mask_wide());
      @(posedge clk); #1;
      check("R1", "qa after edge", qa, 25'h1234567 & mask_wide());
   endtask

   task automatic t_cfg_switch();
      apply(1'b0, 1'b0, 25'h1FFFFFF);
      @(negedge clk);
      cfg_dup = 1'b1;
      cfg_map = 1'b1;
      #1;
      check("R8", "qa keeps wide map", qa, mask_wide());
      check("R8", "qb still low", qb, '0);
      @(posedge clk); #1;
      check("R8", "qa new map B", qa, mask_dup_b());
      check("R8", "qb new map B", qb, mask_dup_b());
      @(negedge clk);
      cfg_map = 1'b0;
      @(posedge clk); #1;
      check("R8", "qa new map A", qa, mask_dup_a());
   endtask

   task automatic t_async_reset();
      apply(1'b0, 1'b1, 25'h1FFFFFF);
      @(negedge clk);
      #1;
      rst_n = 1'b0;
      #0.5;
      check("R7", "qa cleared before edge", qa, '0);
      check("R7", "qb cleared before edge", qb, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R7", "capture resumes after reset", qa, mask_dup_a());
   endtask

   initial begin
      t_reset();
      t_wide();
      t_dup_a();
      t_dup_b();
      t_edge();
      t_cfg_switch();
      t_async_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule